// File: doc/BRIEF.md
# H-Bridge Channel Mode Decoder

This block turns the control pins of one motor channel into four gate commands for an H-bridge: a high-side and a low-side enable for each of the two legs. Two control pins are read under one of two interpretations, chosen at run time by a mode pin. In enable/phase mode one pin enables the bridge and the other picks the direction. In independent-input mode the two pins select open, forward, reverse or brake directly. A brake pin, a power-enable pin and a fault flag override normal drive. Brake closes both low sides. Standby and fault open all four switches and win over brake.

The pins are brought into the clock domain through a configurable synchroniser. The decoded state then passes through one leg controller per leg. A leg controller never closes a switch until its complementary switch has been open for a programmable number of clock cycles. One instance serves one channel. A multi-channel driver places one instance per channel, and every instance runs independently of the others.

Top module: `hbd_mode_decoder`

## Requirements
- R1: With `mode_sel` = 0 (enable/phase), `ctl_a` = 0 opens all four switches. With `ctl_a` = 1, `ctl_b` = 0 gives forward (`hs_a`=1, `ls_b`=1, others 0) and `ctl_b` = 1 gives reverse (`ls_a`=1, `hs_b`=1, others 0).
- R2: With `mode_sel` = 1 (independent inputs), {`ctl_a`,`ctl_b`} = 00 is open, 10 is forward, 01 is reverse and 11 is brake (`ls_a`=1, `ls_b`=1, high sides 0).
- R3: `brake` = 1 gives the brake output pattern in either mode, whatever the control pins are.
- R4: `pwr_on` = 0 opens all four switches, overriding brake and the control pins.
- R5: `fault` = 1 opens all four switches, overriding brake and the control pins.
- R6: A change that needs no dead time reaches the outputs on exactly the (SYNC_STAGES+1)-th rising edge after it is applied at the pins.
- R7: The high-side and low-side switch of one leg are never closed at the same time.
- R8: Once a switch opens, the complementary switch of the same leg closes no earlier than max(`dead_cycles`,1) full clock cycles later. If it is requested all along, it closes exactly then. This holds up to the largest `dead_cycles` value.
- R9: A switch that closes again on the same side of its leg as the last one closed is not held back by the dead time.
- R10: During reset, and after reset while in standby, all four outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dead_cycles | input | DT_W | Dead time in clock cycles (quasi-static) |
| mode_sel | input | 1 | 0 = enable/phase, 1 = independent inputs |
| ctl_a | input | 1 | Control pin A (enable in enable/phase mode) |
| ctl_b | input | 1 | Control pin B (phase in enable/phase mode) |
| brake | input | 1 | 1 = brake, both low sides closed |
| pwr_on | input | 1 | 0 = standby, all switches open |
| fault | input | 1 | 1 = fault, all switches open |
| hs_a | output | 1 | Leg A high-side gate enable |
| ls_a | output | 1 | Leg A low-side gate enable |
| hs_b | output | 1 | Leg B high-side gate enable |
| ls_b | output | 1 | Leg B low-side gate enable |

## Verification
The dead-time property compares each gap in a leg against the current `dead_cycles` value. It therefore assumes that value does not change while a leg is between opening one switch and closing its complement. The stimulus changes it only while the outputs have settled in a steady state. The properties also assume that the synchronised copies of the pins are the only view of the pins the logic has. The stimulus drives every pin on the falling clock edge, so each pin value is held for whole cycles, and the sample points are computed from the synchroniser depth.

// File: rtl/hbd_pkg.sv
package hbd_pkg;

  typedef enum logic [1:0] {
    ST_OPEN  = 2'd0,
    ST_FWD   = 2'd1,
    ST_REV   = 2'd2,
    ST_BRAKE = 2'd3
  } drive_t;

  typedef enum logic [1:0] {
    SIDE_NONE = 2'd0,
    SIDE_HI   = 2'd1,
    SIDE_LO   = 2'd2
  } side_t;

  // Priority: kill (standby/fault) > brake > mode-specific decode.
  function automatic drive_t decode_drive(
    input logic inin_mode,
    input logic pin_a,
    input logic pin_b,
    input logic brk,
    input logic kill
  );
    drive_t r;
    if (kill) begin
      r = ST_OPEN;
    end else if (brk) begin
      r = ST_BRAKE;
    end else if (inin_mode) begin
      case ({pin_a, pin_b})
        2'b10:   r = ST_FWD;
        2'b01:   r = ST_REV;
        2'b11:   r = ST_BRAKE;
        default: r = ST_OPEN;
      endcase
    end else if (!pin_a) begin
      r = ST_OPEN;
    end else begin
      r = pin_b ? ST_REV : ST_FWD;
    end
    return r;
  endfunction

  // Gate request vector ordered {hs_a, ls_a, hs_b, ls_b}.
  function automatic logic [3:0] gate_request(input drive_t s);
    logic [3:0] g;
    case (s)
      ST_FWD:   g = 4'b1001;
      ST_REV:   g = 4'b0110;
      ST_BRAKE: g = 4'b0101;
      default:  g = 4'b0000;
    endcase
    return g;
  endfunction

endpackage

// File: rtl/hbd_sync.sv
module hbd_sync #(
  parameter int W      = 6,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  generate
    if (STAGES == 0) begin : g_bypass
      assign q = d;
    end else begin : g_chain
      logic [W-1:0] stage_q [STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
        end else begin
          stage_q[0] <= d;
          for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
      end
      assign q = stage_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/hbd_decode.sv
module hbd_decode
  import hbd_pkg::*;
(
  input  logic       inin_mode,
  input  logic       pin_a,
  input  logic       pin_b,
  input  logic       brk,
  input  logic       pwr_on,
  input  logic       fault,
  output logic       kill,
  output drive_t     state,
  output logic [3:0] gate_req
);

  assign kill     = !pwr_on || fault;
  assign state    = decode_drive(inin_mode, pin_a, pin_b, brk, kill);
  assign gate_req = gate_request(state);

endmodule

// File: rtl/hbd_leg.sv
module hbd_leg
  import hbd_pkg::*;
#(
  parameter int DT_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DT_W-1:0] dead_cycles,
  input  logic            req_hi,
  input  logic            req_lo,
  output logic            gate_hi,
  output logic            gate_lo
);

  localparam logic [DT_W-1:0] CNT_MAX = {DT_W{1'b1}};
  localparam logic [DT_W-1:0] CNT_ONE = DT_W'(1);

  side_t           last_q;
  logic [DT_W-1:0] off_cnt_q;

  function automatic logic [DT_W-1:0] sat_inc(input logic [DT_W-1:0] v);
    return (v == CNT_MAX) ? v : v + CNT_ONE;
  endfunction

  // A switch may close at once if the other side was not the last one closed;
  // otherwise the leg must already have been open for dead_cycles cycles.
  function automatic logic may_close(input side_t last, input side_t want,
                                     input logic [DT_W-1:0] cnt,
                                     input logic [DT_W-1:0] dt);
    logic opposite;
    opposite = (last != SIDE_NONE) && (last != want);
    return !opposite || (cnt >= dt);
  endfunction

  logic drop_now;
  logic close_hi;
  logic close_lo;

  assign drop_now = (gate_hi && !req_hi) || (gate_lo && !req_lo);
  assign close_hi = !gate_hi && !gate_lo && req_hi &&
                    may_close(last_q, SIDE_HI, off_cnt_q, dead_cycles);
  assign close_lo = !gate_hi && !gate_lo && req_lo && !req_hi &&
                    may_close(last_q, SIDE_LO, off_cnt_q, dead_cycles);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_hi   <= 1'b0;
      gate_lo   <= 1'b0;
      last_q    <= SIDE_NONE;
      off_cnt_q <= CNT_MAX;
    end else if (drop_now) begin
      gate_hi   <= 1'b0;
      gate_lo   <= 1'b0;
      off_cnt_q <= CNT_ONE;
    end else if (!gate_hi && !gate_lo) begin
      off_cnt_q <= sat_inc(off_cnt_q);
      if (close_hi) begin
        gate_hi <= 1'b1;
        last_q  <= SIDE_HI;
      end else if (close_lo) begin
        gate_lo <= 1'b1;
        last_q  <= SIDE_LO;
      end
    end
  end

endmodule

// File: rtl/hbd_mode_decoder.sv
module hbd_mode_decoder
  import hbd_pkg::*;
#(
  parameter int DT_W        = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DT_W-1:0] dead_cycles,
  input  logic            mode_sel,
  input  logic            ctl_a,
  input  logic            ctl_b,
  input  logic            brake,
  input  logic            pwr_on,
  input  logic            fault,
  output logic            hs_a,
  output logic            ls_a,
  output logic            hs_b,
  output logic            ls_b
);

  localparam int PIN_W = 6;
  localparam int LEGS  = 2;

  logic [PIN_W-1:0] pins_raw;
  logic [PIN_W-1:0] pins_s;
  logic             mode_s, a_s, b_s, brake_s, pwr_s, fault_s;
  logic             kill_s;
  drive_t           dec_state;
  logic [3:0]       gate_req;
  logic [LEGS-1:0]  leg_req_hi, leg_req_lo, leg_hi, leg_lo;

  assign pins_raw = {mode_sel, ctl_a, ctl_b, brake, pwr_on, fault};

  hbd_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) sync_i (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pins_raw),
    .q     (pins_s)
  );

  assign {mode_s, a_s, b_s, brake_s, pwr_s, fault_s} = pins_s;

  hbd_decode dec_i (
    .inin_mode (mode_s),
    .pin_a     (a_s),
    .pin_b     (b_s),
    .brk       (brake_s),
    .pwr_on    (pwr_s),
    .fault     (fault_s),
    .kill      (kill_s),
    .state     (dec_state),
    .gate_req  (gate_req)
  );

  // Leg 0 = A takes request bits [3:2], leg 1 = B takes [1:0].
  assign leg_req_hi = {gate_req[1], gate_req[3]};
  assign leg_req_lo = {gate_req[0], gate_req[2]};

  generate
    for (genvar g = 0; g < LEGS; g++) begin : g_leg
      hbd_leg #(.DT_W(DT_W)) leg_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .dead_cycles (dead_cycles),
        .req_hi      (leg_req_hi[g]),
        .req_lo      (leg_req_lo[g]),
        .gate_hi     (leg_hi[g]),
        .gate_lo     (leg_lo[g])
      );
    end
  endgenerate

  assign hs_a = leg_hi[0];
  assign ls_a = leg_lo[0];
  assign hs_b = leg_hi[1];
  assign ls_b = leg_lo[1];

endmodule

// File: rtl/hbd_checker.sv
module hbd_checker
  import hbd_pkg::*;
#(
  parameter int DT_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic [DT_W-1:0] dead_cycles,
  input logic            hs_a,
  input logic            ls_a,
  input logic            hs_b,
  input logic            ls_b,
  input logic            kill_s,
  input logic            brake_s,
  input drive_t          dec_state
);

  localparam int GW = DT_W + 1;
  localparam logic [GW-1:0] GAP_MAX = {GW{1'b1}};

  logic [GW-1:0] gap_a, gap_b, dt_eff;
  logic          lasthi_a, lasthi_b, seen_a, seen_b;

  assign dt_eff = (dead_cycles == '0) ? GW'(1) : {1'b0, dead_cycles};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_a <= '0; gap_b <= '0;
      lasthi_a <= 1'b0; lasthi_b <= 1'b0;
      seen_a <= 1'b0; seen_b <= 1'b0;
    end else begin
      if (hs_a || ls_a) begin
        gap_a <= '0; lasthi_a <= hs_a; seen_a <= 1'b1;
      end else if (gap_a != GAP_MAX) begin
        gap_a <= gap_a + GW'(1);
      end
      if (hs_b || ls_b) begin
        gap_b <= '0; lasthi_b <= hs_b; seen_b <= 1'b1;
      end else if (gap_b != GAP_MAX) begin
        gap_b <= gap_b + GW'(1);
      end
    end
  end

  AST_LEG_A_EXCL: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({hs_a, ls_a})); // R7
  AST_LEG_B_EXCL: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({hs_b, ls_b})); // R7
  AST_KILL_OPENS: assert property (@(posedge clk) disable iff (!rst_n) kill_s |=> !(hs_a || ls_a || hs_b || ls_b)); // R4
  AST_BRAKE_WINS: assert property (@(posedge clk) disable iff (!rst_n) (brake_s && !kill_s) |-> dec_state == ST_BRAKE); // R3
  AST_DEAD_A_LO:  assert property (@(posedge clk) disable iff (!rst_n) ($rose(ls_a) && $past(seen_a) && $past(lasthi_a)) |-> gap_a >= dt_eff); // R8
  AST_DEAD_A_HI:  assert property (@(posedge clk) disable iff (!rst_n) ($rose(hs_a) && $past(seen_a) && !$past(lasthi_a)) |-> gap_a >= dt_eff); // R8
  AST_DEAD_B_LO:  assert property (@(posedge clk) disable iff (!rst_n) ($rose(ls_b) && $past(seen_b) && $past(lasthi_b)) |-> gap_b >= dt_eff); // R8
  AST_DEAD_B_HI:  assert property (@(posedge clk) disable iff (!rst_n) ($rose(hs_b) && $past(seen_b) && !$past(lasthi_b)) |-> gap_b >= dt_eff); // R8

endmodule

bind hbd_mode_decoder hbd_checker #(.DT_W(DT_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .dead_cycles (dead_cycles),
  .hs_a        (hs_a),
  .ls_a        (ls_a),
  .hs_b        (hs_b),
  .ls_b        (ls_b),
  .kill_s      (kill_s),
  .brake_s     (brake_s),
  .dec_state   (dec_state)
);

// File: tb/hbd_mode_decoder_tb_top.sv
module hbd_mode_decoder_tb_top;

  localparam int DT_W = 4;
  localparam int SYNC = 2;
  localparam int LAT  = SYNC + 1;

  // Outputs are checked as {hs_a, ls_a, hs_b, ls_b}.
  localparam logic [3:0] O_OPEN = 4'b0000;
  localparam logic [3:0] O_FWD  = 4'b1001;
  localparam logic [3:0] O_REV  = 4'b0110;
  localparam logic [3:0] O_BRK  = 4'b0101;

  // Stimulus is applied as {mode_sel, brake, pwr_on, fault, ctl_a, ctl_b}.
  typedef struct packed {
    logic [3:0] req;
    logic [5:0] stim;
    logic [3:0] expv;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VT [NV] = '{
    '{4'd1, 6'b001000, 4'b0000},  // R1 enable low
    '{4'd1, 6'b001001, 4'b0000},  // R1 enable low, phase high
    '{4'd1, 6'b001010, 4'b1001},  // R1 forward
    '{4'd1, 6'b001011, 4'b0110},  // R1 reverse
    '{4'd2, 6'b101000, 4'b0000},  // R2 00 open
    '{4'd2, 6'b101010, 4'b1001},  // R2 10 forward
    '{4'd2, 6'b101001, 4'b0110},  // R2 01 reverse
    '{4'd2, 6'b101011, 4'b0101},  // R2 11 brake
    '{4'd3, 6'b111010, 4'b0101},  // R3 brake over forward
    '{4'd3, 6'b011011, 4'b0101},  // R3 brake over reverse, enable/phase
    '{4'd3, 6'b011000, 4'b0101},  // R3 brake over disabled
    '{4'd4, 6'b010010, 4'b0000},  // R4 standby over brake
    '{4'd4, 6'b100010, 4'b0000},  // R4 standby over forward
    '{4'd5, 6'b111111, 4'b0000},  // R5 fault over brake
    '{4'd5, 6'b001110, 4'b0000},  // R5 fault over forward
    '{4'd1, 6'b001010, 4'b1001}   // R1 recovery to forward
  };

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [DT_W-1:0] dead_cycles = '0;
  logic            mode_sel = 1'b0, ctl_a = 1'b0, ctl_b = 1'b0;
  logic            brake = 1'b0, pwr_on = 1'b0, fault = 1'b0;
  logic            hs_a, ls_a, hs_b, ls_b;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  hbd_mode_decoder #(.DT_W(DT_W), .SYNC_STAGES(SYNC)) dut_i (
    .clk (clk), .rst_n (rst_n), .dead_cycles (dead_cycles),
    .mode_sel (mode_sel), .ctl_a (ctl_a), .ctl_b (ctl_b),
    .brake (brake), .pwr_on (pwr_on), .fault (fault),
    .hs_a (hs_a), .ls_a (ls_a), .hs_b (hs_b), .ls_b (ls_b)
  );

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drive(input logic [5:0] s);
    {mode_sel, brake, pwr_on, fault, ctl_a, ctl_b} = s;
  endtask

  task automatic chk(input string tag, input logic [3:0] expv);
    logic [3:0] act;
    act = {hs_a, ls_a, hs_b, ls_b};
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s act=%b exp=%b t=%0t", tag, act, expv, $time);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R10: reset and standby
    edges(3);
    chk("R10 in reset", O_OPEN);
    rst_n = 1'b1;
    edges(5);
    chk("R10 standby after reset", O_OPEN);

    // Vector table, dead time 0: any transition settles within LAT+1 edges
    for (int i = 0; i < NV; i++) begin
      drive(VT[i].stim);
      edges(LAT + 3);
      chk($sformatf("R%0d vec%0d", VT[i].req, i), VT[i].expv);
    end

    dead_cycles = DT_W'(3);

    // R6: latency from open to forward
    drive(6'b101000);
    edges(10);
    drive(6'b101010);
    edges(LAT - 1);
    chk("R6 before latency", O_OPEN);
    edges(1);
    chk("R6 at latency", O_FWD);

    // R9: open then forward again, no dead time on the same side
    drive(6'b101000);
    edges(1);
    drive(6'b101010);
    edges(LAT - 1);
    chk("R9 legs opened", O_OPEN);
    edges(1);
    chk("R9 same side closes at once", O_FWD);

    // R8: forward -> reverse with dead time 3
    drive(6'b101001);
    edges(LAT + 2);
    chk("R8 still in dead time", O_OPEN);
    edges(1);
    chk("R8 reverse after dead time", O_REV);

    // R3: reverse -> brake, leg A stays closed low, leg B waits
    drive(6'b111001);
    edges(LAT + 2);
    chk("R3 leg B in dead time", 4'b0100);
    edges(1);
    chk("R3 brake after dead time", O_BRK);

    // R8: largest dead time, forward -> reverse
    drive(6'b101010);
    edges(10);
    chk("R8 forward settled", O_FWD);
    dead_cycles = '1;
    edges(2);
    drive(6'b101001);
    for (int k = 1; k <= LAT + 15; k++) begin
      edges(1);
      n_chk++;
      if ((hs_a && ls_a) || (hs_b && ls_b)) begin
        n_bad++;
        $display("FAIL R7 act=%b exp=no shoot-through", {hs_a, ls_a, hs_b, ls_b});
      end
      if (k == LAT + 14) chk("R8 max dead time pending", O_OPEN);
      if (k == LAT + 15) chk("R8 max dead time done", O_REV);
    end

    // R5: fault while driving
    drive(6'b101101);
    edges(LAT);
    chk("R5 fault opens", O_OPEN);

    // R4: standby while braking
    drive(6'b111011);
    edges(20);
    chk("R3 brake restored", O_BRK);
    drive(6'b110011);
    edges(LAT);
    chk("R4 standby opens brake", O_OPEN);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule